// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

One channel of a periodic timer. A 32-bit down-counter advances by one step each time a power-of-two prescaler, driven by the block clock, reaches the end of its period. When the counter is stepped at zero, it loads a programmable reload value and sets a sticky underflow flag. That flag, gated by an enable bit, drives one registered interrupt output. Software clears the flag by writing zero to it.

Four 32-bit registers sit on a word-indexed port. The port takes the byte offset shifted right by two. Index 0 is the reload value, 1 the live count, 2 the control word and 3 a capture register. The capture register exists only when the `HAS_CAPTURE` parameter is set. Counting runs only while the `start` input is high.

Control word layout: bits [2:0] are the prescaler code, bit 5 is the interrupt enable, bit 8 is the underflow flag and bit 9 is a capture flag that always reads 0. Bits [15:10] and the other low bits are stored as written.

Top module: `reload_timer_chan`

## Requirements
- R1: `reg_sel` chooses the register: 0 reload, 1 count, 2 control, 3 capture. `rd_data` shows the register picked by `reg_sel` one clock after that `reg_sel` is applied.
- R2: With `start` high, prescaler codes 0, 1, 2, 3 and 4 in control bits [2:0] step the counter once every 4, 16, 64, 256 and 1024 clocks respectively.
- R3: `irq` equals the underflow flag (control bit 8) AND the enable (control bit 5), one clock after both are present. A set flag with the enable at 0 leaves `irq` low.
- R4: A control write with bit 8 equal to 0 clears the flag. A control write with bit 8 equal to 1 leaves the flag unchanged. An underflow in the same clock as a clearing write sets the flag.
- R5: Control bit 9 always reads 0. Bits [15:10] are stored as written. Bits [31:16] read 0.
- R6: After reset, reload and count read 0xFFFFFFFF, control reads 0 and `irq` is low.
- R7: With `HAS_CAPTURE`=1, index 3 is a read/write register. With `HAS_CAPTURE`=0, index 3 reads 0 and writes to it have no effect.
- R8: While `start` is low, neither the count nor the prescaler phase advances.
- R9: A prescaled step taken at count 0 loads the reload value and sets the flag. Any other step decrements the count by 1.
- R10: A count write in the same clock as a prescaled step stores the written value, and the step is dropped.
- R11: Prescaler codes 5, 6 and 7 stop the counter.
- R12: When the prescaler code changes, the prescaler phase restarts from zero. This restart takes one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also the prescaler input |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Counting runs while high |
| wr_en | input | 1 | Write strobe for the register selected by `reg_sel` |
| reg_sel | input | 2 | Register word index (byte offset >> 2) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Registered underflow interrupt |

## Verification
A write lands at the clock edge where `wr_en` is sampled. Read data comes one edge after `reg_sel` is applied. The interrupt follows the flag and enable by one further edge. The count moves on the edge that ends each full prescaler period, and a code change first spends one edge restarting the phase. The bench therefore drives `start` for an exact number of edges and then lowers it, so the count freezes. It reads values back through the port only after the counter has stopped. Every expected count is a whole multiple of the prescaler period, worked out from R2 and R9, and the bench inserts a spacer write after each code change.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned CTRL_W    = 16;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned IE_BIT    = 5;
  localparam int unsigned FLAG_BIT  = 8;
  localparam int unsigned CFLAG_BIT = 9;
  localparam int unsigned NUM_RATES = 5;

  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_CAPT   = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned NUM_RATES = 5,
  parameter int unsigned BASE_LOG2 = 2,
  parameter int unsigned STEP_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned CNT_W = BASE_LOG2 + STEP_LOG2 * (NUM_RATES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic [SEL_W-1:0] sel_q;
  logic             valid_sel;
  logic             resync;

  always_comb begin
    valid_sel = int'(sel) < int'(NUM_RATES);
    lim = '0;
    for (int k = 0; k < int'(NUM_RATES); k++) begin
      if (int'(sel) == k) lim = CNT_W'((64'd1 << (BASE_LOG2 + STEP_LOG2 * k)) - 64'd1);
    end
  end

  assign resync = (sel != sel_q);
  assign tick   = run && valid_sel && !resync && (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else if (resync) begin
      cnt_q <= '0;
      sel_q <= sel;
    end else if (run && valid_sel) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          cnt_wr,
  input  logic          reload_wr,
  input  logic          flag_clr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] count,
  output logic [DW-1:0] reload,
  output logic          flag
);
  logic underflow;

  assign underflow = tick && !cnt_wr && (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '1;
      reload <= '1;
      flag   <= 1'b0;
    end else begin
      if (reload_wr) reload <= wdata;
      if (cnt_wr)         count <= wdata;
      else if (underflow) count <= reload;
      else if (tick)      count <= count - 1'b1;
      if (underflow)     flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/reload_timer_chan.sv
module reload_timer_chan #(
  parameter int unsigned DW          = tmr_pkg::DW,
  parameter bit          HAS_CAPTURE = 1'b0,
  parameter int unsigned BASE_LOG2   = 2,
  parameter int unsigned STEP_LOG2   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wr_en,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  import tmr_pkg::*;

  localparam logic [CTRL_W-1:0] CTRL_KEEP =
    ~((CTRL_W'(1) << FLAG_BIT) | (CTRL_W'(1) << CFLAG_BIT));

  reg_idx_e          idx;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DW-1:0]     count_w, reload_w, capt_rd, ctrl_view;
  logic              flag_w, tick_w;
  logic              ctrl_wr, cnt_wr, reload_wr, capt_wr;

  assign idx       = reg_idx_e'(reg_sel);
  assign ctrl_wr   = wr_en && (idx == REG_CTRL);
  assign cnt_wr    = wr_en && (idx == REG_COUNT);
  assign reload_wr = wr_en && (idx == REG_RELOAD);
  assign capt_wr   = wr_en && (idx == REG_CAPT);

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wr_data[CTRL_W-1:0] & CTRL_KEEP;
  end

  tmr_prescale #(
    .SEL_W(SEL_W), .NUM_RATES(NUM_RATES),
    .BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2)
  ) u_prescale (
    .clk(clk), .rst(rst), .run(start),
    .sel(ctrl_q[SEL_W-1:0]), .tick(tick_w)
  );

  tmr_core #(.DW(DW)) u_core (
    .clk(clk), .rst(rst), .tick(tick_w),
    .cnt_wr(cnt_wr), .reload_wr(reload_wr),
    .flag_clr(ctrl_wr && !wr_data[FLAG_BIT]),
    .wdata(wr_data), .count(count_w), .reload(reload_w), .flag(flag_w)
  );

  generate
    if (HAS_CAPTURE) begin : g_capt
      logic [DW-1:0] capt_q;
      always_ff @(posedge clk) begin
        if (rst)          capt_q <= '0;
        else if (capt_wr) capt_q <= wr_data;
      end
      assign capt_rd = capt_q;
    end else begin : g_nocapt
      logic unused_wr;
      assign unused_wr = capt_wr;
      assign capt_rd   = '0;
    end
  endgenerate

  assign ctrl_view = DW'(ctrl_q) | (DW'(flag_w) << FLAG_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= flag_w && ctrl_q[IE_BIT];
      unique case (idx)
        REG_RELOAD: rd_data <= reload_w;
        REG_COUNT:  rd_data <= count_w;
        REG_CTRL:   rd_data <= ctrl_view;
        REG_CAPT:   rd_data <= capt_rd;
      endcase
    end
  end
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          wr_en,
  input logic [1:0]    reg_sel,
  input logic [DW-1:0] wr_data,
  input logic          irq,
  input logic          tick,
  input logic [DW-1:0] count,
  input logic [DW-1:0] reload,
  input logic          flag,
  input logic          ie,
  input logic [2:0]    sel
);
  logic cnt_wr, ctrl_wr, uf;
  assign cnt_wr  = wr_en && (reg_sel == 2'd1);
  assign ctrl_wr = wr_en && (reg_sel == 2'd2);
  assign uf      = tick && !cnt_wr && (count == '0);

  // R3
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(flag && ie)));

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!start && !cnt_wr) |=> $stable(count));

  // R9
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    uf |=> (count == $past(reload)) && flag);

  // R10
  wr_prio_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (count == $past(wr_data)));

  // R4
  flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !wr_data[8] && !uf) |=> !flag);

  // R11
  no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (sel > 3'd4) |-> !tick);
endmodule

bind reload_timer_chan tmr_chan_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .reg_sel(reg_sel),
  .wr_data(wr_data), .irq(irq), .tick(tick_w), .count(count_w),
  .reload(reload_w), .flag(flag_w), .ie(ctrl_q[5]), .sel(ctrl_q[2:0])
);

// File: tb/test_reload_timer_chan.sv
module test_reload_timer_chan;
  logic        clk = 1'b0, rst = 1'b1, start = 1'b0, wr_en = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, rd_data_nc;
  logic        irq, irq_nc;
  int vectors = 0, miscompares = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          src_q[$];
  logic        rd_req = 1'b0, rd_req_d = 1'b0;

  always #2 clk = ~clk;

  reload_timer_chan #(.HAS_CAPTURE(1'b1)) i_reload_timer_chan (
    .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  reload_timer_chan #(.HAS_CAPTURE(1'b0)) i_reload_timer_chan_nc (
    .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data_nc), .irq(irq_nc));

  always_ff @(posedge clk) rd_req_d <= rd_req;

  // monitor: compares the read data due one edge after each request
  always @(negedge clk) begin
    if (rd_req_d && exp_q.size() > 0) begin
      logic [31:0] e, g;
      string t;
      bit s;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      s = src_q.pop_front();
      g = s ? rd_data_nc : rd_data;
      vectors++;
      if (g !== e) begin
        miscompares++;
        $display("FAIL %s: got %h expected %h", t, g, e);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_sel = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input bit nc, input string t);
    reg_sel = a; rd_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t); src_q.push_back(nc);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic run(input int n);
    start = 1'b1;
    repeat (n) @(negedge clk);
    start = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    vectors++;
    if (irq !== e) begin
      miscompares++;
      $display("FAIL %s: irq got %b expected %b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R6 reset state
    rd(2'd0, 32'hFFFF_FFFF, 0, "R6 reload reset");
    rd(2'd1, 32'hFFFF_FFFF, 0, "R6 count reset");
    rd(2'd2, 32'h0, 0, "R6 control reset");
    chk_irq(1'b0, "R6 irq reset");
    // R7 capture gating
    wr(2'd3, 32'h1234_5678);
    rd(2'd3, 32'h1234_5678, 0, "R7 capture present");
    rd(2'd3, 32'h0, 1, "R7 capture absent");
    // R9 decrement and reload, R3 interrupt
    wr(2'd0, 32'd5);
    wr(2'd1, 32'd2);
    wr(2'd2, 32'h20);
    run(8);
    rd(2'd1, 32'd0, 0, "R9 decrement to zero");
    rd(2'd2, 32'h20, 0, "R9 no flag before underflow");
    run(4);
    rd(2'd1, 32'd5, 0, "R9 reload on underflow");
    rd(2'd2, 32'h120, 0, "R9 flag set");
    chk_irq(1'b1, "R3 irq with enable");
    rd(2'd0, 32'd5, 0, "R1 reload index");
    // R4 flag keep / clear, R5 bit handling
    wr(2'd2, 32'h120);
    rd(2'd2, 32'h120, 0, "R4 write one keeps flag");
    chk_irq(1'b1, "R4 irq kept");
    wr(2'd2, 32'hFFFF_FE20);
    rd(2'd2, 32'hFC20, 0, "R5 bit9 zero, upper bits stored");
    chk_irq(1'b0, "R4 irq after clear");
    wr(2'd2, 32'h0);
    // R3 flag without enable
    wr(2'd1, 32'd0);
    run(4);
    rd(2'd1, 32'd5, 0, "R9 reload from zero");
    rd(2'd2, 32'h100, 0, "R3 flag visible");
    chk_irq(1'b0, "R3 irq masked");
    wr(2'd2, 32'h0);
    // R8 freeze
    wr(2'd1, 32'd40);
    repeat (20) @(negedge clk);
    rd(2'd1, 32'd40, 0, "R8 frozen count");
    run(2);
    repeat (10) @(negedge clk);
    run(2);
    rd(2'd1, 32'd39, 0, "R8 prescaler phase held");
    // R2 all rates
    for (int s = 0; s < 5; s++) begin
      wr(2'd2, 32'(s));
      wr(2'd1, 32'd100);
      run((4 << (2 * s)) - 1);
      rd(2'd1, 32'd100, 0, "R2 before period end");
      run(1);
      rd(2'd1, 32'd99, 0, "R2 at period end");
    end
    // R11 stopped codes
    wr(2'd2, 32'd5);
    wr(2'd1, 32'd7);
    run(2100);
    rd(2'd1, 32'd7, 0, "R11 code 5 stopped");
    wr(2'd2, 32'd7);
    run(300);
    rd(2'd1, 32'd7, 0, "R11 code 7 stopped");
    // R12 phase restart on code change
    wr(2'd2, 32'd0);
    wr(2'd1, 32'd30);
    run(2);
    wr(2'd2, 32'd1);
    wr(2'd2, 32'd0);
    wr(2'd1, 32'd30);
    run(3);
    rd(2'd1, 32'd30, 0, "R12 phase restarted");
    run(1);
    rd(2'd1, 32'd29, 0, "R12 step after restart");
    // R10 write beats step
    wr(2'd1, 32'd50);
    run(3);
    reg_sel = 2'd1; wr_data = 32'd77; wr_en = 1'b1; start = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; start = 1'b0;
    rd(2'd1, 32'd77, 0, "R10 write wins");
    run(4);
    rd(2'd1, 32'd76, 0, "R10 next step");
    @(negedge clk);
    finish_run();
  end
endmodule